// File: doc/BRIEF.md
# Floating-Point Unit Issue and Occupancy Controller

This block models only the timing of a floating-point unit. It takes one decoded instruction word per cycle through a valid/ready handshake and does no arithmetic. The primary and extended opcode fields sort each accepted word into one of four kinds. Most operations go through a three-stage pipeline, one cycle per stage. The double-precision multiply-add stays in the first stage for an extra cycle. The two divides are iterative and lock the whole unit for 17 or 31 cycles. A word that matches no known encoding raises a one-cycle illegal flag and does not enter the unit. Each accepted operation returns its 4-bit tag on the completion output when it finishes.

The controller sits beside the issue logic of a core. `in_ready` is a combinational function of the current occupancy and of the word on `in_instr`. Issue logic keeps presenting a word until `in_ready` accepts it. Results are reported on `done_valid` and `done_tag`, with at most one completion per cycle.

Top module: `fpu_issue_ctrl`

## Requirements
- R1: One cycle after a synchronous reset, `done_valid` and `illegal` are low and `in_ready` is high for a non-divide word.
- R2: Fields use big-endian bit numbering. The primary opcode is `in_instr[31:26]`, the 5-bit extended code is `in_instr[5:1]` and the 10-bit extended code is `in_instr[10:1]`. All other bits, including `in_instr[0]`, have no effect on decoding. Primary 59 selects single precision and primary 63 selects double precision. The 5-bit code is matched first, with 18 = divide, 21 = add and 29 = multiply-add.
- R3: Single-stage-per-cycle operations are add (59/21, 63/21) and the primary-63 10-bit codes 0, 14, 15, 32, 72 and 264. Each completes in the 3rd cycle after acceptance, carrying its tag. One such operation can be accepted every cycle.
- R4: A double-precision multiply-add (63/29) completes in the 4th cycle after acceptance. `in_ready` is low in the 1st cycle after acceptance and only in that cycle, unless another rule also holds it low.
- R5: A single-precision multiply-add (59/29) behaves like an add: it completes in the 3rd cycle and does not block the next cycle.
- R6: A single-precision divide (59/18) completes in the 17th cycle after acceptance. `in_ready` is low for every word from the 1st through the 17th cycle.
- R7: A double-precision divide (63/18) completes in the 31st cycle after acceptance. `in_ready` is low from the 1st through the 31st cycle.
- R8: A divide word sees `in_ready` low while any of the three pipeline stages is occupied.
- R9: Every accepted word that is not listed in R2 through R7 raises `illegal` for exactly the following cycle and never produces a completion.
- R10: `done_valid` is high only in a cycle where an operation is due to complete, and `done_tag` then equals the tag that was accepted with that operation.
- R11: A reset asserted while operations are in flight discards them all, so none of them completes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction word is presented |
| in_instr | input | 32 | Instruction word, bit 31 = big-endian bit 0 |
| in_tag | input | 4 | Tag to return on completion |
| in_ready | output | 1 | The presented word is accepted at this edge if valid |
| done_valid | output | 1 | An operation completes this cycle |
| done_tag | output | 4 | Tag of the completing operation |
| illegal | output | 1 | The word accepted at the previous edge was rejected |

## Verification
The embedded assertions assume the unit starts under reset. They also assume that issue logic moves a word in only when `in_ready` is high, so the start and entry strobes seen by the stage and divide submodules never arrive while those submodules are busy. The stimulus respects this by treating an edge as a transfer only when `in_valid` and `in_ready` are both high. It may drop or change a refused word freely, as real issue logic would. Random traffic mixes every legal kind with three illegal encodings, random don't-care bits and occasional mid-flight resets. This drives divides against an occupied pipeline and puts words behind a multiply-add hold.

// File: rtl/fpu_issue_pkg.sv
`timescale 1ns/1ps
package fpu_issue_pkg;

  localparam logic [5:0] PRI_SGL = 6'd59;
  localparam logic [5:0] PRI_DBL = 6'd63;
  localparam logic [4:0] XS_DIV  = 5'd18;
  localparam logic [4:0] XS_ADD  = 5'd21;
  localparam logic [4:0] XS_FMA  = 5'd29;

  typedef enum logic [2:0] {
    OPC_BAD,
    OPC_PIPE,
    OPC_PIPE_HOLD,
    OPC_DIV_S,
    OPC_DIV_D
  } op_class_e;

  function automatic logic [5:0] prim_field(input logic [31:0] w);
    return w[31:26];
  endfunction

  function automatic logic [4:0] xs_field(input logic [31:0] w);
    return w[5:1];
  endfunction

  function automatic logic [9:0] xl_field(input logic [31:0] w);
    return w[10:1];
  endfunction

  function automatic logic is_long_form(input logic [9:0] x);
    case (x)
      10'd0, 10'd14, 10'd15, 10'd32, 10'd72, 10'd264: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic op_class_e classify_op(input logic [31:0] w);
    logic [5:0] p;
    logic       dbl;
    op_class_e  c;
    p   = prim_field(w);
    dbl = (p == PRI_DBL);
    c   = OPC_BAD;
    if (p == PRI_SGL || dbl) begin
      case (xs_field(w))
        XS_DIV:  c = dbl ? OPC_DIV_D : OPC_DIV_S;
        XS_ADD:  c = OPC_PIPE;
        XS_FMA:  c = dbl ? OPC_PIPE_HOLD : OPC_PIPE;
        default: c = (dbl && is_long_form(xl_field(w))) ? OPC_PIPE : OPC_BAD;
      endcase
    end
    return c;
  endfunction

  function automatic int unsigned iter_length(input logic long_form,
                                              input int unsigned short_len,
                                              input int unsigned long_len);
    return long_form ? long_len : short_len;
  endfunction

endpackage

// File: rtl/fpu_op_decode.sv
`timescale 1ns/1ps
module fpu_op_decode
  import fpu_issue_pkg::*;
(
  input  logic [31:0] instr,
  output logic        is_pipe,
  output logic        is_hold,
  output logic        is_div,
  output logic        is_long_div,
  output logic        is_bad
);
  op_class_e cls;

  always_comb begin
    cls         = classify_op(instr);
    is_pipe     = (cls == OPC_PIPE);
    is_hold     = (cls == OPC_PIPE_HOLD);
    is_div      = (cls == OPC_DIV_S) || (cls == OPC_DIV_D);
    is_long_div = (cls == OPC_DIV_D);
    is_bad      = (cls == OPC_BAD);
  end
endmodule

// File: rtl/fpu_stage_pipe.sv
`timescale 1ns/1ps
module fpu_stage_pipe #(
  parameter int TAG_W     = 4,
  parameter int NSTAGES   = 3,
  parameter int FIRST_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic             enter_hold,
  input  logic [TAG_W-1:0] enter_tag,
  output logic             stall_first,
  output logic             empty,
  output logic             done,
  output logic [TAG_W-1:0] done_tag
);
  localparam int HW = $clog2(FIRST_CYC + 1);

  logic [NSTAGES-1:0] v;
  logic [TAG_W-1:0]   t [NSTAGES];
  logic [HW-1:0]      hold_left;
  logic [NSTAGES-1:0] fwd;   // stage i hands its entry onward this cycle

  assign stall_first = v[0] && (hold_left != '0);
  assign fwd[0]      = v[0] && !stall_first;
  assign empty       = (v == '0);
  assign done        = v[NSTAGES-1];
  assign done_tag    = t[NSTAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      v[0]      <= 1'b0;
      hold_left <= '0;
    end else if (enter) begin
      v[0]      <= 1'b1;
      hold_left <= enter_hold ? HW'(FIRST_CYC - 1) : '0;
    end else if (stall_first) begin
      hold_left <= hold_left - 1'b1;
    end else begin
      v[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (enter) t[0] <= enter_tag;
  end

  for (genvar gi = 1; gi < NSTAGES; gi++) begin : g_stage
    if (gi < NSTAGES - 1) begin : g_mid
      assign fwd[gi] = v[gi];
    end else begin : g_last
      assign fwd[gi] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) v[gi] <= 1'b0;
      else     v[gi] <= fwd[gi-1];
    end

    always_ff @(posedge clk) begin
      t[gi] <= t[gi-1];
    end

    // R3: an entry handed on by the previous stage appears here with its tag
    a_r3_stage_shift: assert property (@(posedge clk) disable iff (rst)
      fwd[gi-1] |=> v[gi] && (t[gi] == $past(t[gi-1])));
  end

  // R4: while the first stage is held, no new entry arrives and the held one stays
  a_r4_no_entry_while_held: assert property (@(posedge clk) disable iff (rst)
    stall_first |-> !enter);
  a_r4_hold_keeps_entry: assert property (@(posedge clk) disable iff (rst)
    stall_first |=> v[0] && $stable(t[0]));

  // R3: a plain entry does not stall the first stage
  a_r3_plain_no_stall: assert property (@(posedge clk) disable iff (rst)
    enter && !enter_hold |=> !stall_first);
endmodule

// File: rtl/fpu_iter_unit.sv
`timescale 1ns/1ps
module fpu_iter_unit
  import fpu_issue_pkg::*;
#(
  parameter int TAG_W     = 4,
  parameter int SHORT_CYC = 17,
  parameter int LONG_CYC  = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_long,
  input  logic [TAG_W-1:0] start_tag,
  output logic             busy,
  output logic             done,
  output logic [TAG_W-1:0] done_tag
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0]    remain;
  logic [TAG_W-1:0] tag_q;
  logic             last_cycle;

  assign busy       = (remain != '0);
  assign last_cycle = (remain == CW'(1));
  assign done       = last_cycle;
  assign done_tag   = tag_q;

  always_ff @(posedge clk) begin
    if (rst)        remain <= '0;
    else if (start) remain <= CW'(iter_length(start_long, SHORT_CYC, LONG_CYC));
    else if (busy)  remain <= remain - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (start) tag_q <= start_tag;
  end

  // R6: the remaining count falls by one each busy cycle until the last
  a_r6_countdown: assert property (@(posedge clk) disable iff (rst)
    busy && !last_cycle |=> remain == $past(remain) - 1'b1);
  // R6: no new divide starts while one is running
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
  // R7: the tag is held for the whole run
  a_r7_tag_held: assert property (@(posedge clk) disable iff (rst)
    busy && !last_cycle |=> $stable(tag_q));
endmodule

// File: rtl/fpu_issue_ctrl.sv
`timescale 1ns/1ps
module fpu_issue_ctrl #(
  parameter int TAG_W     = 4,
  parameter int NSTAGES   = 3,
  parameter int FIRST_CYC = 2,
  parameter int DIV_S_CYC = 17,
  parameter int DIV_D_CYC = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      in_instr,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_ready,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag,
  output logic             illegal
);
  logic             dec_pipe, dec_hold, dec_div, dec_long, dec_bad;
  logic             accept, go_pipe, go_div, go_bad;
  logic             stall_first, pipe_empty, pipe_done;
  logic [TAG_W-1:0] pipe_tag;
  logic             div_busy, div_done;
  logic [TAG_W-1:0] div_tag;
  logic             illegal_q;

  fpu_op_decode u_dec (
    .instr       (in_instr),
    .is_pipe     (dec_pipe),
    .is_hold     (dec_hold),
    .is_div      (dec_div),
    .is_long_div (dec_long),
    .is_bad      (dec_bad)
  );

  assign in_ready = !div_busy && !stall_first && !(dec_div && !pipe_empty);
  assign accept   = in_valid && in_ready;
  assign go_pipe  = accept && (dec_pipe || dec_hold);
  assign go_div   = accept && dec_div;
  assign go_bad   = accept && dec_bad;

  fpu_stage_pipe #(
    .TAG_W     (TAG_W),
    .NSTAGES   (NSTAGES),
    .FIRST_CYC (FIRST_CYC)
  ) u_pipe (
    .clk         (clk),
    .rst         (rst),
    .enter       (go_pipe),
    .enter_hold  (dec_hold),
    .enter_tag   (in_tag),
    .stall_first (stall_first),
    .empty       (pipe_empty),
    .done        (pipe_done),
    .done_tag    (pipe_tag)
  );

  fpu_iter_unit #(
    .TAG_W     (TAG_W),
    .SHORT_CYC (DIV_S_CYC),
    .LONG_CYC  (DIV_D_CYC)
  ) u_iter (
    .clk        (clk),
    .rst        (rst),
    .start      (go_div),
    .start_long (dec_long),
    .start_tag  (in_tag),
    .busy       (div_busy),
    .done       (div_done),
    .done_tag   (div_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) illegal_q <= 1'b0;
    else     illegal_q <= go_bad;
  end

  assign illegal    = illegal_q;
  assign done_valid = pipe_done || div_done;
  assign done_tag   = pipe_done ? pipe_tag : div_tag;

  // R10: the two completion sources never report in the same cycle
  a_r10_single_source: assert property (@(posedge clk) disable iff (rst)
    !(pipe_done && div_done));
  // R8: a divide only starts on an empty pipeline
  a_r8_div_on_empty: assert property (@(posedge clk) disable iff (rst)
    go_div |-> pipe_empty);
  // R6: a running divide blocks every issue
  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !in_ready);
  // R4: acceptance of a double multiply-add blocks the following cycle
  a_r4_hold_bubble: assert property (@(posedge clk) disable iff (rst)
    go_pipe && dec_hold |=> !in_ready);
  // R9: a rejected word is flagged in the next cycle
  a_r9_reject_flag: assert property (@(posedge clk) disable iff (rst)
    go_bad |=> illegal);
endmodule

// File: tb/fpu_issue_ctrl_test.sv
`timescale 1ns/1ps
module fpu_issue_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [3:0]  in_tag = '0;
  logic        in_ready, done_valid, illegal;
  logic [3:0]  done_tag;

  always #5 clk = ~clk;

  fpu_issue_ctrl uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_tag(in_tag), .in_ready(in_ready), .done_valid(done_valid),
    .done_tag(done_tag), .illegal(illegal)
  );

  // kinds: 0 bad, 1 plain, 2 double fma, 3 single div, 4 double div, 5 single fma
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  int j = 0;
  int exp_cyc[$];
  logic [3:0] exp_tg[$];
  string exp_rq[$];
  int pipe_last, div_last, fma_at, bad_at, rst_at;
  logic [3:0] next_tag = 4'd0;

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s at interval %0d: actual=%0d expected=%0d", rq, what, j, act, expv);
    end
  endtask

  task automatic model_clear();
    exp_cyc.delete(); exp_tg.delete(); exp_rq.delete();
    pipe_last = -100; div_last = -100; fma_at = -100; bad_at = -100;
  endtask

  function automatic logic [31:0] make_word(input logic [5:0] p, input int xo,
                                            input bit long_xo);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = p;
    if (long_xo) w[10:1] = 10'(xo);
    else         w[5:1]  = 5'(xo);
    return w;
  endfunction

  task automatic gen(input int sel, output logic [31:0] w, output int kind);
    int longs[6] = '{0, 14, 15, 32, 72, 264};
    case (sel)
      0: begin w = make_word(6'd59, 21, 0); kind = 1; end
      1: begin w = make_word(6'd63, 21, 0); kind = 1; end
      2: begin w = make_word(6'd59, 29, 0); kind = 5; end
      3: begin w = make_word(6'd63, 29, 0); kind = 2; end
      4: begin w = make_word(6'd59, 18, 0); kind = 3; end
      5: begin w = make_word(6'd63, 18, 0); kind = 4; end
      6: begin w = make_word(6'd63, longs[$urandom_range(0, 5)], 1); kind = 1; end
      7: begin w = make_word(6'd59, 20, 0); kind = 0; end
      8: begin w = make_word(6'd63, 40, 1); kind = 0; end
      default: begin w = make_word(6'd31, 21, 0); kind = 0; end
    endcase
  endtask

  function automatic bit model_ready(input int kind);
    if (div_last >= j) return 0;
    if (fma_at == j) return 0;
    if ((kind == 3 || kind == 4) && pipe_last >= j) return 0;
    return 1;
  endfunction

  function automatic string ready_reason(input int kind);
    if (div_last >= j) return "R6 R7";
    if (fma_at == j) return "R4";
    if ((kind == 3 || kind == 4) && pipe_last >= j) return "R8";
    return "R3 R5";
  endfunction

  // one interval: drive at the falling edge, check, then take the rising edge
  task automatic step(input bit v, input int sel);
    logic [31:0] w;
    int kind, k;
    bit er, fire, ed;
    string drq;
    gen(sel, w, kind);
    in_valid = v; in_instr = w; in_tag = next_tag;
    #1;
    er = model_ready(kind);
    check(in_ready == er, ready_reason(kind), "in_ready", in_ready, er);
    ed = (exp_cyc.size() > 0) && (exp_cyc[0] == j);
    drq = ed ? exp_rq[0] : ((j < rst_at + 40) ? "R11" : "R10");
    check(done_valid == ed, drq, "done_valid", done_valid, ed);
    if (ed) begin
      check(done_tag == exp_tg[0], "R10", "done_tag", done_tag, exp_tg[0]);
      void'(exp_cyc.pop_front()); void'(exp_tg.pop_front()); void'(exp_rq.pop_front());
    end
    check(illegal == (bad_at == j), "R9 R2", "illegal", illegal, bad_at == j);
    fire = v && er;
    @(posedge clk);
    j++;
    k = j;
    if (fire) begin
      case (kind)
        0: bad_at = k;
        1: begin exp_cyc.push_back(k + 2); exp_tg.push_back(next_tag);
                 exp_rq.push_back("R3 R2"); pipe_last = k + 2; end
        5: begin exp_cyc.push_back(k + 2); exp_tg.push_back(next_tag);
                 exp_rq.push_back("R5"); pipe_last = k + 2; end
        2: begin exp_cyc.push_back(k + 3); exp_tg.push_back(next_tag);
                 exp_rq.push_back("R4"); pipe_last = k + 3; fma_at = k; end
        3: begin exp_cyc.push_back(k + 16); exp_tg.push_back(next_tag);
                 exp_rq.push_back("R6"); div_last = k + 16; end
        default: begin exp_cyc.push_back(k + 30); exp_tg.push_back(next_tag);
                 exp_rq.push_back("R7"); div_last = k + 30; end
      endcase
      next_tag = next_tag + 4'd1;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  task automatic mid_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    j++;
    model_clear();
    rst_at = j;
    #1;
    check(done_valid == 1'b0, "R11", "done_valid after reset", done_valid, 0);
    check(illegal == 1'b0, "R11", "illegal after reset", illegal, 0);
  endtask

  initial begin
    model_clear();
    rst_at = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(done_valid == 1'b0, "R1", "done_valid", done_valid, 0);
    check(illegal == 1'b0, "R1", "illegal", illegal, 0);
    check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);

    // R3: plain operations back to back, including the long forms
    step(1, 0); step(1, 1); step(1, 6); step(1, 6); idle(4);
    // R4: a follower is refused for one interval, then accepted
    step(1, 3); step(1, 0); step(1, 0); idle(5);
    // R5: single multiply-add leaves no bubble
    step(1, 2); step(1, 1); idle(4);
    // R8 then R6: divide presented while the pipeline drains
    step(1, 0); for (int i = 0; i < 5; i++) step(1, 4);
    idle(20);
    // R7: double divide holding everything off
    step(1, 5); for (int i = 0; i < 32; i++) step(1, 1);
    idle(4);
    // R9: rejected encodings back to back
    step(1, 7); step(1, 8); step(1, 9); step(1, 0); idle(4);
    // R11: in-flight work dropped by reset
    step(1, 1); step(1, 3); mid_reset(); idle(6);
    step(1, 5); idle(3); mid_reset(); idle(40);

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 599) == 0) mid_reset();
      else step($urandom_range(0, 9) < 7, $urandom_range(0, 10));
    end
    idle(40);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule